// File: doc/BRIEF.md
# Line-Buffered Video Burst Sequencer

This block connects a slow, continuous parallel pixel stream to a faster camera-serial packet transmitter. Pixels arrive at one per pixel clock. Capture starts on a vertical sync. Each line is then stored, starting on the next horizontal sync, in a dual-clock line RAM that holds several lines. Only a line that has been fully written is handed to the transmit side.

The transmit side runs on the faster byte clock and works the packet stream. It requests a frame-start packet, then one line packet per completed line, and a frame-end packet once the frame's line count has been sent. Between bursts the link stays idle, which at nominal rates is roughly one input line time. Downstream sees two handshakes: a packet request carrying a 2-bit command, and a pixel beat stream with a last marker.

The two domains exchange only Gray-coded line counters and a frame toggle.

Top module: `line_burst_seq`

## Requirements
- R1: While and after reset, `req_valid_o` and `dat_valid_o` are low and both error flags are clear.
- R2: Horizontal syncs and pixels are ignored until the first vertical sync. After a vertical sync, each horizontal sync stores the `LINE_PIX` pixels presented in the cycles that immediately follow it.
- R3: A packet request keeps `req_valid_o` and `req_cmd_o` unchanged until `req_ready_i` is high. The command codes are 2'b00 for frame-start, 2'b01 for frame-end and 2'b10 for a line; 2'b11 never appears.
- R4: A line request is issued only after every pixel of that line has been written. It is followed by exactly `LINE_PIX` beats in capture order, and `dat_last_o` is high on the final beat only.
- R5: Each frame is sent as frame-start, then `FRAME_LINES` line packets, then frame-end. Horizontal syncs after the last line of a frame are ignored until the next vertical sync.
- R6: When no completed line or frame event is pending, `req_valid_o` and `dat_valid_o` are both low.
- R7: While `dat_ready_i` is low, a valid beat keeps `dat_valid_o`, `dat_o` and `dat_last_o` unchanged.
- R8: A vertical sync that arrives before `FRAME_LINES` lines have been stored has two effects. First, the stored lines are sent and then a frame-end is emitted for the short frame, before the new frame-start. Second, a line that is only partly written at that moment is discarded.
- R9: A horizontal sync that arrives while `FIFO_LINES` stored lines are still unsent sets the sticky `ovf_err_o`. The rest of that frame is then dropped. Lines stored earlier are still sent, and capture restarts at the next vertical sync.
- R10: `unf_err_o` is sticky and is set if a beat is offered when no completed line is stored. It stays low in correct operation.
- R11: `req_valid_o` and `dat_valid_o` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pix_clk_i | input | 1 | Pixel clock |
| byte_clk_i | input | 1 | Transmit clock, at least twice the pixel clock |
| rst_ni | input | 1 | Active-low asynchronous reset, both domains |
| vsync_i | input | 1 | Vertical sync pulse (pixel domain) |
| hsync_i | input | 1 | Horizontal sync pulse (pixel domain) |
| pix_i | input | PIX_W | Pixel data, one per pixel cycle after hsync |
| req_valid_o | output | 1 | Packet request valid |
| req_cmd_o | output | 2 | Packet command: 00 frame-start, 01 frame-end, 10 line |
| req_ready_i | input | 1 | Packet request accepted |
| dat_valid_o | output | 1 | Line beat valid |
| dat_o | output | PIX_W | Line beat pixel |
| dat_last_o | output | 1 | Final beat of a line |
| dat_ready_i | input | 1 | Line beat accepted |
| ovf_err_o | output | 1 | Sticky overflow flag (pixel domain) |
| unf_err_o | output | 1 | Sticky underflow flag (byte domain) |

## Verification
The overflow case is the hardest to reach from the ports, because the transmit side normally drains far faster than lines arrive. The bench reaches it by holding both ready inputs low. The transmitter then stalls on its first frame-start request, so two lines sit unsent when the third horizontal sync comes. Releasing ready must then produce exactly those two lines, and nothing more until the next vertical sync.

The short frame with a partly written line is built by driving a vertical sync three pixels into a line. Random backpressure from an LFSR covers the hold rules.

// File: rtl/lbs_pkg.sv
package lbs_pkg;
  typedef enum logic [1:0] {
    CMD_FS   = 2'b00,
    CMD_FE   = 2'b01,
    CMD_LINE = 2'b10
  } cmd_e;
endpackage

// File: rtl/lbs_gray_sync.sv
// Binary counter -> Gray register (source) -> 2FF -> binary (destination).
module lbs_gray_sync #(
  parameter int W = 2
) (
  input  logic         src_clk_i,
  input  logic         dst_clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] bin_i,
  output logic [W-1:0] bin_o
);
  logic [W-1:0] gray_q, s1_q, s2_q;

  always_ff @(posedge src_clk_i or negedge rst_ni)
    if (!rst_ni) gray_q <= '0;
    else         gray_q <= bin_i ^ (bin_i >> 1);

  always_ff @(posedge dst_clk_i or negedge rst_ni)
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= gray_q;
      s2_q <= s1_q;
    end

  always_comb begin
    bin_o[W-1] = s2_q[W-1];
    for (int i = W - 2; i >= 0; i--) bin_o[i] = bin_o[i+1] ^ s2_q[i];
  end
endmodule

// File: rtl/lbs_line_ram.sv
module lbs_line_ram #(
  parameter int DW    = 8,
  parameter int DEPTH = 1280,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          wclk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge wclk_i)
    if (we_i) mem_q[waddr_i] <= wdata_i;

  // read side only touches committed lines, so an unregistered read is stable
  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/lbs_capture.sv
module lbs_capture #(
  parameter int LINE_PIX    = 640,
  parameter int FRAME_LINES = 480,
  parameter int FIFO_LINES  = 2,
  parameter int PIX_W       = 8,
  localparam int IW  = $clog2(LINE_PIX),
  localparam int LNW = $clog2(FRAME_LINES + 1),
  localparam int CW  = $clog2(FIFO_LINES) + 1,
  localparam int AW  = $clog2(FIFO_LINES * LINE_PIX)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             vsync_i,
  input  logic             hsync_i,
  input  logic [PIX_W-1:0] pix_i,
  input  logic [CW-1:0]    rd_line_i,
  output logic [CW-1:0]    wr_line_o,
  output logic             frame_tgl_o,
  output logic             we_o,
  output logic [AW-1:0]    waddr_o,
  output logic [PIX_W-1:0] wdata_o,
  output logic             ovf_err_o
);
  typedef enum logic [1:0] {C_WAIT_VS, C_WAIT_HS, C_ACTIVE} cap_st_e;

  localparam logic [AW-1:0]  LP_A     = AW'(LINE_PIX);
  localparam logic [IW-1:0]  IDX_LAST = IW'(LINE_PIX - 1);
  localparam logic [LNW-1:0] LN_LAST  = LNW'(FRAME_LINES - 1);

  cap_st_e        st_q;
  logic [IW-1:0]  idx_q;
  logic [LNW-1:0] lif_q;
  logic [CW-1:0]  wr_line_q, fill;
  logic           tgl_q, ovf_q, full;

  assign fill = wr_line_q - rd_line_i;
  assign full = (fill == CW'(FIFO_LINES));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= C_WAIT_VS;
      idx_q     <= '0;
      lif_q     <= '0;
      wr_line_q <= '0;
      tgl_q     <= 1'b0;
      ovf_q     <= 1'b0;
    end else if (vsync_i) begin
      // new frame; an uncommitted partial line is simply abandoned
      tgl_q <= ~tgl_q;
      lif_q <= '0;
      st_q  <= C_WAIT_HS;
    end else begin
      unique case (st_q)
        C_WAIT_HS: if (hsync_i) begin
          if (full) begin
            ovf_q <= 1'b1;
            st_q  <= C_WAIT_VS;
          end else begin
            idx_q <= '0;
            st_q  <= C_ACTIVE;
          end
        end
        C_ACTIVE: begin
          idx_q <= idx_q + 1'b1;
          if (idx_q == IDX_LAST) begin
            wr_line_q <= wr_line_q + 1'b1;
            lif_q     <= lif_q + 1'b1;
            st_q      <= (lif_q == LN_LAST) ? C_WAIT_VS : C_WAIT_HS;
          end
        end
        default: ;
      endcase
    end
  end

  assign we_o        = (st_q == C_ACTIVE) && !vsync_i;
  assign waddr_o     = AW'(wr_line_q[CW-2:0]) * LP_A + AW'(idx_q);
  assign wdata_o     = pix_i;
  assign wr_line_o   = wr_line_q;
  assign frame_tgl_o = tgl_q;
  assign ovf_err_o   = ovf_q;
endmodule

// File: rtl/lbs_tx_seq.sv
module lbs_tx_seq
  import lbs_pkg::*;
#(
  parameter int LINE_PIX    = 640,
  parameter int FRAME_LINES = 480,
  parameter int FIFO_LINES  = 2,
  parameter int PIX_W       = 8,
  localparam int IW  = $clog2(LINE_PIX),
  localparam int LNW = $clog2(FRAME_LINES + 1),
  localparam int CW  = $clog2(FIFO_LINES) + 1,
  localparam int AW  = $clog2(FIFO_LINES * LINE_PIX)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CW-1:0]    wr_line_i,
  input  logic             frame_tgl_i,
  output logic [CW-1:0]    rd_line_o,
  output logic [AW-1:0]    raddr_o,
  input  logic [PIX_W-1:0] rdata_i,
  output logic             req_valid_o,
  output logic [1:0]       req_cmd_o,
  input  logic             req_ready_i,
  output logic             dat_valid_o,
  output logic [PIX_W-1:0] dat_o,
  output logic             dat_last_o,
  input  logic             dat_ready_i,
  output logic             unf_err_o
);
  typedef enum logic [2:0] {T_IDLE, T_SOF, T_WAIT, T_LREQ, T_LDAT, T_EOF} tx_st_e;

  localparam logic [AW-1:0]  LP_A     = AW'(LINE_PIX);
  localparam logic [IW-1:0]  IDX_LAST = IW'(LINE_PIX - 1);
  localparam logic [LNW-1:0] LN_LAST  = LNW'(FRAME_LINES - 1);

  tx_st_e         st_q;
  logic [CW-1:0]  rd_line_q, tgt_q;
  logic [IW-1:0]  idx_q;
  logic [LNW-1:0] sent_q;
  logic           pend_q, tgl_q, unf_q;
  logic           avail, at_tgt, frame_evt;

  assign avail     = (wr_line_i != rd_line_q);
  assign at_tgt    = (rd_line_q == tgt_q);
  assign frame_evt = (frame_tgl_i != tgl_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= T_IDLE;
      rd_line_q <= '0;
      tgt_q     <= '0;
      idx_q     <= '0;
      sent_q    <= '0;
      pend_q    <= 1'b0;
      tgl_q     <= 1'b0;
      unf_q     <= 1'b0;
    end else begin
      tgl_q <= frame_tgl_i;
      unique case (st_q)
        T_IDLE: if (pend_q && at_tgt) begin
          pend_q <= 1'b0;
          st_q   <= T_SOF;
        end
        T_SOF: if (req_ready_i) begin
          sent_q <= '0;
          st_q   <= T_WAIT;
        end
        // lines stored before the frame event drain first, then the short frame closes
        T_WAIT: begin
          if (pend_q && at_tgt) st_q <= T_EOF;
          else if (avail)       st_q <= T_LREQ;
        end
        T_LREQ: if (req_ready_i) begin
          idx_q <= '0;
          st_q  <= T_LDAT;
        end
        T_LDAT: begin
          if (!avail) unf_q <= 1'b1;
          if (dat_ready_i) begin
            idx_q <= idx_q + 1'b1;
            if (idx_q == IDX_LAST) begin
              rd_line_q <= rd_line_q + 1'b1;
              sent_q    <= sent_q + 1'b1;
              st_q      <= (sent_q == LN_LAST) ? T_EOF : T_WAIT;
            end
          end
        end
        T_EOF: if (req_ready_i) st_q <= T_IDLE;
        default: st_q <= T_IDLE;
      endcase
      if (frame_evt) begin
        pend_q <= 1'b1;
        tgt_q  <= wr_line_i;
      end
    end
  end

  always_comb begin
    req_valid_o = 1'b0;
    req_cmd_o   = CMD_FS;
    unique case (st_q)
      T_SOF:  req_valid_o = 1'b1;
      T_LREQ: begin req_valid_o = 1'b1; req_cmd_o = CMD_LINE; end
      T_EOF:  begin req_valid_o = 1'b1; req_cmd_o = CMD_FE;   end
      default: ;
    endcase
  end

  assign dat_valid_o = (st_q == T_LDAT);
  assign dat_last_o  = dat_valid_o && (idx_q == IDX_LAST);
  assign dat_o       = rdata_i;
  assign raddr_o     = AW'(rd_line_q[CW-2:0]) * LP_A + AW'(idx_q);
  assign rd_line_o   = rd_line_q;
  assign unf_err_o   = unf_q;
endmodule

// File: rtl/line_burst_seq.sv
module line_burst_seq #(
  parameter int LINE_PIX    = 640,
  parameter int FRAME_LINES = 480,
  parameter int FIFO_LINES  = 2,   // power of two, >= 2
  parameter int PIX_W       = 8
) (
  input  logic             pix_clk_i,
  input  logic             byte_clk_i,
  input  logic             rst_ni,
  input  logic             vsync_i,
  input  logic             hsync_i,
  input  logic [PIX_W-1:0] pix_i,
  output logic             req_valid_o,
  output logic [1:0]       req_cmd_o,
  input  logic             req_ready_i,
  output logic             dat_valid_o,
  output logic [PIX_W-1:0] dat_o,
  output logic             dat_last_o,
  input  logic             dat_ready_i,
  output logic             ovf_err_o,
  output logic             unf_err_o
);
  localparam int DEPTH = FIFO_LINES * LINE_PIX;
  localparam int CW    = $clog2(FIFO_LINES) + 1;
  localparam int AW    = $clog2(DEPTH);

  logic [CW-1:0]    wr_line_p, wr_line_b, rd_line_b, rd_line_p;
  logic             tgl_p, tgl_b, we;
  logic [AW-1:0]    waddr, raddr;
  logic [PIX_W-1:0] wdata, rdata;

  lbs_capture #(
    .LINE_PIX(LINE_PIX), .FRAME_LINES(FRAME_LINES),
    .FIFO_LINES(FIFO_LINES), .PIX_W(PIX_W)
  ) u_cap (
    .clk_i(pix_clk_i), .rst_ni(rst_ni),
    .vsync_i(vsync_i), .hsync_i(hsync_i), .pix_i(pix_i),
    .rd_line_i(rd_line_p), .wr_line_o(wr_line_p), .frame_tgl_o(tgl_p),
    .we_o(we), .waddr_o(waddr), .wdata_o(wdata), .ovf_err_o(ovf_err_o)
  );

  lbs_line_ram #(.DW(PIX_W), .DEPTH(DEPTH)) u_ram (
    .wclk_i(pix_clk_i), .we_i(we), .waddr_i(waddr), .wdata_i(wdata),
    .raddr_i(raddr), .rdata_o(rdata)
  );

  lbs_gray_sync #(.W(CW)) u_wr_sync (
    .src_clk_i(pix_clk_i), .dst_clk_i(byte_clk_i), .rst_ni(rst_ni),
    .bin_i(wr_line_p), .bin_o(wr_line_b)
  );

  lbs_gray_sync #(.W(CW)) u_rd_sync (
    .src_clk_i(byte_clk_i), .dst_clk_i(pix_clk_i), .rst_ni(rst_ni),
    .bin_i(rd_line_b), .bin_o(rd_line_p)
  );

  lbs_gray_sync #(.W(1)) u_frm_sync (
    .src_clk_i(pix_clk_i), .dst_clk_i(byte_clk_i), .rst_ni(rst_ni),
    .bin_i(tgl_p), .bin_o(tgl_b)
  );

  lbs_tx_seq #(
    .LINE_PIX(LINE_PIX), .FRAME_LINES(FRAME_LINES),
    .FIFO_LINES(FIFO_LINES), .PIX_W(PIX_W)
  ) u_tx (
    .clk_i(byte_clk_i), .rst_ni(rst_ni),
    .wr_line_i(wr_line_b), .frame_tgl_i(tgl_b),
    .rd_line_o(rd_line_b), .raddr_o(raddr), .rdata_i(rdata),
    .req_valid_o(req_valid_o), .req_cmd_o(req_cmd_o), .req_ready_i(req_ready_i),
    .dat_valid_o(dat_valid_o), .dat_o(dat_o), .dat_last_o(dat_last_o),
    .dat_ready_i(dat_ready_i), .unf_err_o(unf_err_o)
  );
endmodule

// File: rtl/lbs_checker.sv
module lbs_checker #(
  parameter int PIX_W = 8
) (
  input logic             pix_clk_i,
  input logic             byte_clk_i,
  input logic             rst_ni,
  input logic             req_valid_o,
  input logic [1:0]       req_cmd_o,
  input logic             req_ready_i,
  input logic             dat_valid_o,
  input logic [PIX_W-1:0] dat_o,
  input logic             dat_last_o,
  input logic             dat_ready_i,
  input logic             ovf_err_o,
  input logic             unf_err_o
);
  a_r3_req_hold: assert property (@(posedge byte_clk_i) disable iff (!rst_ni)
    req_valid_o && !req_ready_i |=> req_valid_o && $stable(req_cmd_o));

  a_r3_cmd_legal: assert property (@(posedge byte_clk_i) disable iff (!rst_ni)
    req_valid_o |-> req_cmd_o != 2'b11);

  a_r7_dat_hold: assert property (@(posedge byte_clk_i) disable iff (!rst_ni)
    dat_valid_o && !dat_ready_i |=> dat_valid_o && $stable(dat_o) && $stable(dat_last_o));

  a_r4_last_valid: assert property (@(posedge byte_clk_i) disable iff (!rst_ni)
    dat_last_o |-> dat_valid_o);

  a_r11_exclusive: assert property (@(posedge byte_clk_i) disable iff (!rst_ni)
    !(req_valid_o && dat_valid_o));

  a_r9_ovf_sticky: assert property (@(posedge pix_clk_i) disable iff (!rst_ni)
    ovf_err_o |=> ovf_err_o);

  a_r10_unf_sticky: assert property (@(posedge byte_clk_i) disable iff (!rst_ni)
    unf_err_o |=> unf_err_o);

  a_r10_no_unf: assert property (@(posedge byte_clk_i) disable iff (!rst_ni)
    !unf_err_o);
endmodule

bind line_burst_seq lbs_checker #(.PIX_W(PIX_W)) u_chk (
  .pix_clk_i(pix_clk_i), .byte_clk_i(byte_clk_i), .rst_ni(rst_ni),
  .req_valid_o(req_valid_o), .req_cmd_o(req_cmd_o), .req_ready_i(req_ready_i),
  .dat_valid_o(dat_valid_o), .dat_o(dat_o), .dat_last_o(dat_last_o),
  .dat_ready_i(dat_ready_i), .ovf_err_o(ovf_err_o), .unf_err_o(unf_err_o)
);

// File: tb/sim_line_burst_seq.sv
`timescale 1ns/1ps
module sim_line_burst_seq;
  localparam int LP = 8, FL = 4, FLN = 2, PW = 8;

  logic bclk = 1'b0, pclk = 1'b0, rst_n = 1'b0;
  always #2 bclk = ~bclk;   // 250 MHz
  always #4 pclk = ~pclk;

  logic vsync = 1'b0, hsync = 1'b0;
  logic [PW-1:0] pix = '0;
  logic req_valid, dat_valid, dat_last, ovf, unf;
  logic [1:0] cmd;
  logic [PW-1:0] dat;
  logic req_rdy, dat_rdy;

  int mode = 0;
  logic [15:0] lfsr = 16'hACE1;
  always @(posedge bclk) begin
    #1 lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  end
  assign req_rdy = (mode == 0) ? 1'b1 : (mode == 1) ? lfsr[0] : 1'b0;
  assign dat_rdy = (mode == 0) ? 1'b1 : (mode == 1) ? lfsr[3] : 1'b0;

  line_burst_seq #(.LINE_PIX(LP), .FRAME_LINES(FL), .FIFO_LINES(FLN), .PIX_W(PW)) u0 (
    .pix_clk_i(pclk), .byte_clk_i(bclk), .rst_ni(rst_n),
    .vsync_i(vsync), .hsync_i(hsync), .pix_i(pix),
    .req_valid_o(req_valid), .req_cmd_o(cmd), .req_ready_i(req_rdy),
    .dat_valid_o(dat_valid), .dat_o(dat), .dat_last_o(dat_last), .dat_ready_i(dat_rdy),
    .ovf_err_o(ovf), .unf_err_o(unf)
  );

  int checks = 0, fails = 0;
  int exp_q[$];
  int stored_total = 0, line_reqs = 0, bursts_done = 0, beat = 0, gidx = 0;
  int m_lines = 0;
  bit m_capt = 0, m_open = 0, m_drop = 0, in_burst = 0;

  task automatic chk(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic logic [PW-1:0] pv(int g, int k);
    return PW'((g * 37 + k * 5 + 3) & 255);
  endfunction

  // output monitor, sampled mid-cycle
  logic p_dv = 0, p_dr = 0, p_dl = 0, p_rv = 0, p_rr = 0;
  logic [PW-1:0] p_d = '0;
  logic [1:0] p_c = '0;
  always @(negedge bclk) begin
    if (rst_n) begin
      int code, e;
      if (exp_q.size() == 0)
        chk(!req_valid && !dat_valid, "R6 idle while nothing pending", {req_valid, dat_valid}, 0);
      chk(!(req_valid && dat_valid), "R11 exclusive", {req_valid, dat_valid}, 0);
      if (p_rv && !p_rr)
        chk(req_valid && cmd == p_c, "R3 request hold", {req_valid, cmd}, {1'b1, p_c});
      if (p_dv && !p_dr)
        chk(dat_valid && dat == p_d && dat_last == p_dl, "R7 beat hold", int'(dat), int'(p_d));
      if (req_valid && req_rdy) begin
        code = (cmd == 2'b00) ? -1 : (cmd == 2'b01) ? -2 : (cmd == 2'b10) ? -3 : -9;
        if (exp_q.size() == 0) chk(0, "R5 unexpected packet (R3 code)", code, 0);
        else begin
          e = exp_q.pop_front();
          chk(code == e, "R5 packet order (R3 code)", code, e);
        end
        if (code == -3) begin
          line_reqs++;
          chk(line_reqs <= stored_total, "R4 request after full line", line_reqs, stored_total);
          in_burst = 1;
          beat = 0;
        end
      end
      if (dat_valid && dat_rdy) begin
        chk(in_burst, "R4 beat outside burst", 0, 1);
        if (exp_q.size() == 0) chk(0, "R4 unexpected beat", int'(dat), 0);
        else begin
          e = exp_q.pop_front();
          chk(int'(dat) == e, "R4 beat data", int'(dat), e);
        end
        chk(dat_last == (beat == LP - 1), "R4 last marker", dat_last, beat == LP - 1);
        beat++;
        if (dat_last) begin
          in_burst = 0;
          bursts_done++;
        end
      end
    end
    p_dv = dat_valid; p_dr = dat_rdy; p_dl = dat_last; p_d = dat;
    p_rv = req_valid; p_rr = req_rdy; p_c = cmd;
  end

  task automatic do_vsync();
    @(negedge pclk);
    vsync = 1'b1;
    if (m_open) exp_q.push_back(-2);   // R8 short frame closes first
    exp_q.push_back(-1);
    m_capt = 1; m_open = 1; m_lines = 0; m_drop = 0;
    @(negedge pclk);
    vsync = 1'b0;
    repeat (3) @(negedge pclk);
  endtask

  task automatic do_line(int gap);
    int g;
    bit store;
    @(negedge pclk);
    hsync = 1'b1;
    store = m_capt && !m_drop && (m_lines < FL);
    if (store && (stored_total - bursts_done >= FLN)) begin
      m_drop = 1;     // R9 overflow
      store = 0;
    end
    g = gidx; gidx++;
    for (int k = 0; k < LP; k++) begin
      @(negedge pclk);
      hsync = 1'b0;
      pix = pv(g, k);
    end
    @(negedge pclk);
    pix = '0;
    if (store) begin
      stored_total++;
      exp_q.push_back(-3);
      for (int k = 0; k < LP; k++) exp_q.push_back(int'(pv(g, k)));
      m_lines++;
      if (m_lines == FL) begin
        exp_q.push_back(-2);
        m_open = 0;
      end
    end
    repeat (gap) @(negedge pclk);
  endtask

  task automatic partial_line(int n);
    @(negedge pclk);
    hsync = 1'b1;
    for (int k = 0; k < n; k++) begin
      @(negedge pclk);
      hsync = 1'b0;
      pix = PW'(8'hA0 + k);
    end
  endtask

  task automatic drain(string req);
    int t = 0;
    while (exp_q.size() != 0 && t < 4000) begin
      @(negedge bclk);
      t++;
    end
    repeat (40) @(negedge bclk);
    chk(exp_q.size() == 0, req, exp_q.size(), 0);
  endtask

  initial begin
    repeat (150000) @(posedge bclk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge bclk);
    chk(!req_valid && !dat_valid, "R1 valids low in reset", {req_valid, dat_valid}, 0);
    repeat (4) @(negedge pclk);
    rst_n = 1'b1;
    @(negedge bclk);
    chk(!req_valid, "R1 req_valid after reset", req_valid, 0);
    chk(!dat_valid, "R1 dat_valid after reset", dat_valid, 0);
    chk(!ovf && !unf, "R1 errors clear", {ovf, unf}, 0);

    // R2: lines before any vertical sync are ignored
    do_line(4);
    do_line(4);
    drain("R2 no output before vsync");

    // R5: full frame plus one surplus line that must be ignored
    mode = 0;
    do_vsync();
    for (int i = 0; i < FL + 1; i++) do_line(4);
    drain("R5 frame complete");

    // R7: random backpressure on both handshakes
    mode = 1;
    do_vsync();
    for (int i = 0; i < FL; i++) do_line(14);
    drain("R7 frame under backpressure");
    mode = 0;

    // R8: short frame ending in a partly written line
    do_vsync();
    do_line(4);
    do_line(4);
    partial_line(3);
    do_vsync();
    for (int i = 0; i < FL; i++) do_line(4);
    drain("R8 short frame then full frame");

    // R9: stall output so two lines sit unsent, third hsync overflows
    chk(!ovf, "R9 no overflow yet", ovf, 0);
    mode = 2;
    do_vsync();
    for (int i = 0; i < FL; i++) do_line(4);
    repeat (6) @(negedge pclk);
    chk(ovf, "R9 overflow flagged", ovf, 1);
    mode = 0;
    drain("R9 stored lines still sent");
    do_vsync();
    for (int i = 0; i < FL; i++) do_line(4);
    drain("R9 resync on next vsync");
    chk(ovf, "R9 overflow sticky", ovf, 1);
    chk(!unf, "R10 no underflow", unf, 0);
    chk(stored_total == bursts_done, "R4 every stored line sent", bursts_done, stored_total);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule